// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep and Wake

This block receives asynchronous serial frames on a bus shared by several nodes. The line is oversampled by a tick enable. The receiver recovers each frame and hands the data word to software through a ready flag that software acknowledges. A frame is one low start bit, eight or nine payload bits sent least significant bit first, and one high stop bit. When parity is enabled, it takes the last payload position.

Software can put the receiver to sleep, so a node that is not addressed ignores the traffic of other nodes. While asleep, no status flag is raised and the interrupt line stays low. A wake-method select picks how the receiver leaves sleep. In one method it wakes on a quiet line lasting a whole frame. In the other it wakes on a word whose top data bit marks it as an address. That address word is then delivered as ordinary data.

Top module: `mp_uart_rx`

## Requirements
- R1: Four frame formats are supported. With `frame_long`=0 there are 8 payload bits and with `frame_long`=1 there are 9. When `par_en`=1, the last payload bit is the parity bit and the data is 7 or 8 bits. `rx_word` holds the data bits, least significant first, with parity removed and zeros above.
- R2: Each bit is the majority of the samples taken at ticks 7, 8 and 9 of its 16-tick period, counted from the tick that sees the falling edge. A low pulse whose start-bit vote comes out high is discarded and produces no word.
- R3: With `par_odd`=0 the data bits plus the parity bit must hold an even number of ones, and with `par_odd`=1 an odd number. A mismatch sets `par_err` together with the delivered word.
- R4: A stop bit voted low sets `frm_err` with the word. The receiver then waits for the line to return high before it looks for a new start bit.
- R5: `data_rdy` rises when a word is delivered and stays set until an `rd_ack` pulse. That pulse clears `data_rdy`, `par_err`, `frm_err`, `ovr_err` and `idle_seen`.
- R6: A word that completes while `data_rdy` is set raises `ovr_err`. `rx_word` keeps the earlier word.
- R7: After a start bit has been seen, the line may stay high from the end of a frame for a whole frame length: 10 bit times for short frames, 11 for long frames. While not muted, this sets `idle_seen` once. A shorter high period sets nothing.
- R8: A one-cycle `mute_req` pulse sets `muted`. While muted, words are not delivered and none of `data_rdy`, `par_err`, `frm_err`, `ovr_err` or `idle_seen` can be set, except by the address wake of R10.
- R9: With `wake_on_addr`=0, a muted receiver clears `muted` on the idle condition of R7 and leaves `idle_seen` at 0.
- R10: With `wake_on_addr`=1, a muted receiver clears `muted` on a word whose most significant data bit is 1. That word is delivered per R1, R3 to R6. Words with that bit 0, and idle lines, leave it muted.
- R11: The address test uses the top data bit and never the parity bit. With parity enabled, this is the bit just below the parity position.
- R12: If `mute_req` is high in the cycle a wake condition occurs, the receiver stays muted and the word is lost.
- R13: `irq` is high exactly when `muted` is 0 and at least one of the five status flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, OVS ticks per bit |
| rx_line | input | 1 | Serial line, idles high |
| frame_long | input | 1 | 0: 8 payload bits, 1: 9 payload bits |
| par_en | input | 1 | Parity in last payload position |
| par_odd | input | 1 | Odd parity when 1 |
| wake_on_addr | input | 1 | Wake method: 0 idle line, 1 address word |
| mute_req | input | 1 | Software request to enter sleep |
| rd_ack | input | 1 | Read acknowledge, clears status flags |
| rx_word | output | 9 | Received data bits |
| data_rdy | output | 1 | Word available |
| par_err | output | 1 | Parity mismatch on delivered word |
| frm_err | output | 1 | Stop bit low on delivered word |
| ovr_err | output | 1 | Word lost while data_rdy was set |
| idle_seen | output | 1 | Idle frame detected |
| muted | output | 1 | Sleep status |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with the default of 16 ticks per bit and pulses the tick every second clock. This exercises the enable gating and leaves 32 cycles per bit, so a glitch shorter than the vote window can be placed exactly. All four frame formats are driven with random data, corrupted parity and broken stop bits. The sleep cases are directed. They cover wake by idle line and by address word, a parity bit that looks like an address mark, and a mute request held across a waking word.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  localparam int unsigned PAYLOAD_MAX = 9;
  localparam int unsigned IDX_W       = $clog2(PAYLOAD_MAX + 1);

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic rst_n_o,
  output logic dout
);
  logic [STAGES-1:0] rst_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= '0;
    else         rst_q <= {rst_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = rst_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n_o) begin
    if (!rst_n_o) dat_q <= '1;
    else          dat_q <= {dat_q[STAGES-2:0], din};
  end

  assign dout = dat_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_deframe.sv
module mpu_rx_deframe
  import mpu_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   line,
  input  logic                   frame_long,
  output logic                   done,
  output logic                   stop_ok,
  output logic [PAYLOAD_MAX-1:0] raw,
  output logic                   in_idle,
  output logic                   start_seen
);
  localparam int unsigned OVS_W = $clog2(OVS);
  localparam int unsigned MID   = OVS / 2;

  rx_state_e               st_q, st_d;
  logic [OVS_W-1:0]        cnt_q, cnt_d;
  logic [IDX_W-1:0]        bidx_q, bidx_d;
  logic [PAYLOAD_MAX-1:0]  sh_q, sh_d;
  logic [1:0]              smp_q, smp_d;
  logic                    vote, at_vote, at_end;
  logic [IDX_W-1:0]        last_idx;

  assign vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & line) | (smp_q[1] & line);
  assign at_vote  = (cnt_q == OVS_W'(MID + 1));
  assign at_end   = (cnt_q == OVS_W'(OVS - 1));
  assign last_idx = frame_long ? IDX_W'(PAYLOAD_MAX - 1) : IDX_W'(PAYLOAD_MAX - 2);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    bidx_d     = bidx_q;
    sh_d       = sh_q;
    smp_d      = smp_q;
    done       = 1'b0;
    stop_ok    = 1'b0;
    start_seen = 1'b0;
    if (tick) begin
      if (st_q != RX_IDLE && st_q != RX_HOLD)
        cnt_d = at_end ? '0 : cnt_q + OVS_W'(1);
      if (cnt_q == OVS_W'(MID - 1)) smp_d[0] = line;
      if (cnt_q == OVS_W'(MID))     smp_d[1] = line;
      unique case (st_q)
        RX_IDLE: if (!line) begin
          st_d       = RX_START;
          cnt_d      = '0;
          sh_d       = '0;
          start_seen = 1'b1;
        end
        RX_START: begin
          if (at_vote && vote) st_d = RX_IDLE;
          else if (at_end) begin
            st_d   = RX_BITS;
            bidx_d = '0;
          end
        end
        RX_BITS: begin
          if (at_vote) sh_d[bidx_q] = vote;
          if (at_end) begin
            if (bidx_q == last_idx) st_d = RX_STOP;
            else bidx_d = bidx_q + IDX_W'(1);
          end
        end
        RX_STOP: if (at_vote) begin
          done    = 1'b1;
          stop_ok = vote;
          st_d    = vote ? RX_IDLE : RX_HOLD;
        end
        RX_HOLD: if (line) st_d = RX_IDLE;
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      smp_q  <= '1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      smp_q  <= smp_d;
    end
  end

  assign raw     = sh_q;
  assign in_idle = (st_q == RX_IDLE);
endmodule

// File: rtl/mpu_rx_idle_det.sv
module mpu_rx_idle_det
  import mpu_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic in_idle,
  input  logic start_seen,
  input  logic frame_long,
  output logic idle_evt
);
  localparam int unsigned LIM_MAX = (PAYLOAD_MAX + 2) * OVS;
  localparam int unsigned IDLE_W  = $clog2(LIM_MAX + 1);

  logic              armed_q, armed_d;
  logic [IDLE_W-1:0] cnt_q, cnt_d;
  logic [IDLE_W-1:0] lim;

  assign lim = frame_long ? IDLE_W'((PAYLOAD_MAX + 2) * OVS - 1)
                          : IDLE_W'((PAYLOAD_MAX + 1) * OVS - 1);

  always_comb begin
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    idle_evt = 1'b0;
    if (start_seen) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (tick && armed_q && in_idle) begin
      if (!line) cnt_d = '0;
      else if (cnt_q >= lim) begin
        idle_evt = 1'b1;
        armed_d  = 1'b0;
        cnt_d    = '0;
      end else cnt_d = cnt_q + IDLE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   os_tick,
  input  logic                   rx_line,
  input  logic                   frame_long,
  input  logic                   par_en,
  input  logic                   par_odd,
  input  logic                   wake_on_addr,
  input  logic                   mute_req,
  input  logic                   rd_ack,
  output logic [PAYLOAD_MAX-1:0] rx_word,
  output logic                   data_rdy,
  output logic                   par_err,
  output logic                   frm_err,
  output logic                   ovr_err,
  output logic                   idle_seen,
  output logic                   muted,
  output logic                   irq
);
  logic                   rst_n_s, line_s;
  logic                   fr_done, fr_stop_ok, in_idle, start_seen, idle_evt;
  logic [PAYLOAD_MAX-1:0] fr_raw, word_c;
  logic [IDX_W-1:0]       ndata;
  logic                   pbit, addr_bit, par_bad, take;

  logic                   muted_q, muted_d, rdy_q, rdy_d, perr_q, perr_d;
  logic                   ferr_q, ferr_d, ovr_q, ovr_d, idle_q, idle_d;
  logic [PAYLOAD_MAX-1:0] word_q, word_d;

  mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .din(rx_line), .rst_n_o(rst_n_s), .dout(line_s)
  );

  mpu_rx_deframe #(.OVS(OVS)) u_deframe (
    .clk(clk), .rst_n(rst_n_s), .tick(os_tick), .line(line_s),
    .frame_long(frame_long), .done(fr_done), .stop_ok(fr_stop_ok),
    .raw(fr_raw), .in_idle(in_idle), .start_seen(start_seen)
  );

  mpu_rx_idle_det #(.OVS(OVS)) u_idle (
    .clk(clk), .rst_n(rst_n_s), .tick(os_tick), .line(line_s),
    .in_idle(in_idle), .start_seen(start_seen), .frame_long(frame_long),
    .idle_evt(idle_evt)
  );

  // Data width: payload length minus the parity slot.
  assign ndata = (frame_long ? IDX_W'(PAYLOAD_MAX) : IDX_W'(PAYLOAD_MAX - 1))
               - IDX_W'(par_en);

  always_comb begin
    for (int i = 0; i < int'(PAYLOAD_MAX); i++)
      word_c[i] = fr_raw[i] & (i < int'(ndata));
  end

  assign pbit     = fr_raw[ndata];
  assign addr_bit = fr_raw[ndata - IDX_W'(1)];
  assign par_bad  = par_en & (pbit ^ (^word_c) ^ par_odd);
  assign take     = fr_done & (!muted_q | (wake_on_addr & addr_bit & !mute_req));

  always_comb begin
    muted_d = muted_q;
    rdy_d   = rdy_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    ovr_d   = ovr_q;
    idle_d  = idle_q;
    word_d  = word_q;
    if (rd_ack) begin
      rdy_d  = 1'b0;
      perr_d = 1'b0;
      ferr_d = 1'b0;
      ovr_d  = 1'b0;
      idle_d = 1'b0;
    end
    if (take) begin
      muted_d = 1'b0;
      if (rdy_q) ovr_d = 1'b1;
      else begin
        word_d = word_c;
        rdy_d  = 1'b1;
        perr_d = par_bad;
        ferr_d = !fr_stop_ok;
      end
    end
    if (idle_evt) begin
      if (!muted_q)          idle_d  = 1'b1;
      else if (!wake_on_addr) muted_d = 1'b0;
    end
    if (mute_req) muted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      muted_q <= 1'b0;
      rdy_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      idle_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      muted_q <= muted_d;
      rdy_q   <= rdy_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
      idle_q  <= idle_d;
      word_q  <= word_d;
    end
  end

  assign rx_word   = word_q;
  assign data_rdy  = rdy_q;
  assign par_err   = perr_q;
  assign frm_err   = ferr_q;
  assign ovr_err   = ovr_q;
  assign idle_seen = idle_q;
  assign muted     = muted_q;
  assign irq       = !muted_q & (rdy_q | perr_q | ferr_q | ovr_q | idle_q);

  p_no_flags_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(muted_q) && muted_q) |-> !($rose(rdy_q) || $rose(ovr_q) || $rose(perr_q) || $rose(ferr_q)));
  p_idle_wake_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(muted_q) |-> !$rose(idle_q));
  p_mute_wins_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    mute_req |=> muted_q);
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_ack && !fr_done) |=> !rdy_q);
  p_keep_old_word_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rdy_q && !rd_ack) |=> $stable(word_q));
  p_wake_needs_event_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(muted_q) |-> $past(fr_done || idle_evt));
endmodule

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
  localparam int OVS    = 16;
  localparam int BITCYC = 2 * OVS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_line = 1'b1;
  logic frame_long = 1'b0, par_en = 1'b0, par_odd = 1'b0, wake_on_addr = 1'b0;
  logic mute_req = 1'b0, rd_ack = 1'b0;
  logic [8:0] rx_word;
  logic data_rdy, par_err, frm_err, ovr_err, idle_seen, muted, irq;
  int nvec = 0, nbad = 0;

  always #5 clk = ~clk;
  always @(negedge clk) os_tick <= ~os_tick;

  mp_uart_rx #(.OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .frame_long(frame_long), .par_en(par_en), .par_odd(par_odd),
    .wake_on_addr(wake_on_addr), .mute_req(mute_req), .rd_ack(rd_ack),
    .rx_word(rx_word), .data_rdy(data_rdy), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .idle_seen(idle_seen),
    .muted(muted), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ndata_f(input logic fl, input logic pe);
    return (fl ? 9 : 8) - (pe ? 1 : 0);
  endfunction

  function automatic logic [8:0] word_f(input logic [8:0] d, input logic fl, input logic pe);
    logic [8:0] w = '0;
    for (int i = 0; i < ndata_f(fl, pe); i++) w[i] = d[i];
    return w;
  endfunction

  task automatic gap(input int nbits);
    rx_line = 1'b1;
    repeat (nbits * BITCYC) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic bad_par, input logic bad_stop);
    logic [8:0] w = word_f(d, frame_long, par_en);
    int nd = ndata_f(frame_long, par_en);
    int nb = frame_long ? 9 : 8;
    logic [10:0] bits = '0;
    for (int i = 0; i < nd; i++) bits[1 + i] = w[i];
    if (par_en) bits[1 + nd] = (^w) ^ par_odd ^ bad_par;
    bits[nb + 1] = !bad_stop;
    for (int i = 0; i < nb + 2; i++) begin
      rx_line = bits[i];
      repeat (BITCYC) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_mute();
    mute_req = 1'b1;
    @(negedge clk);
    mute_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [8:0] d, a;
    logic bp, bs;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 reset data_rdy", data_rdy, 0);
    chk("R8 reset muted", muted, 0);
    chk("R13 reset irq", irq, 0);
    chk("R7 reset idle_seen", idle_seen, 0);

    // R1 R3 R4 R5 R13: random formats, parity and stop corruption
    for (int n = 0; n < 100; n++) begin
      frame_long = 1'($urandom);
      par_en     = 1'($urandom);
      par_odd    = 1'($urandom);
      d          = 9'($urandom);
      bp         = par_en && ($urandom % 6 == 0);
      bs         = ($urandom % 8 == 0);
      send(d, bp, bs);
      chk("R5 data_rdy set", data_rdy, 1);
      chk("R1 rx_word", rx_word, word_f(d, frame_long, par_en));
      chk("R3 par_err", par_err, bp);
      chk("R4 frm_err", frm_err, bs);
      chk("R13 irq on word", irq, 1);
      ack();
      chk("R5 ack clears rdy", data_rdy, 0);
      chk("R5 ack clears errors", {par_err, frm_err}, 0);
      gap(2);
    end

    // R6 overrun keeps the older word
    frame_long = 1'b0; par_en = 1'b0;
    send(9'h0A5, 1'b0, 1'b0);
    gap(2);
    send(9'h03C, 1'b0, 1'b0);
    chk("R6 ovr_err", ovr_err, 1);
    chk("R6 word kept", rx_word, 9'h0A5);
    ack();
    chk("R5 ack clears ovr", ovr_err, 0);

    // R7 idle detection after a partial and a full quiet period
    gap(5);
    chk("R7 no idle before a frame time", idle_seen, 0);
    gap(9);
    chk("R7 idle_seen", idle_seen, 1);
    chk("R13 irq on idle", irq, 1);
    ack();
    chk("R5 ack clears idle", idle_seen, 0);

    // R2 short low pulse rejected by the start vote
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    gap(3);
    chk("R2 glitch gives no word", data_rdy, 0);
    send(9'h05A, 1'b0, 1'b0);
    chk("R2 frame after glitch", rx_word, 9'h05A);
    ack();
    gap(14);
    ack();

    // R8 R10 R11 address wake with parity enabled, short frame
    wake_on_addr = 1'b1; frame_long = 1'b0; par_en = 1'b1; par_odd = 1'b0;
    pulse_mute();
    chk("R8 muted after request", muted, 1);
    send(9'h001, 1'b0, 1'b1);
    chk("R11 parity bit is not an address mark", muted, 1);
    chk("R8 no rdy while muted", data_rdy, 0);
    chk("R8 no frm_err while muted", frm_err, 0);
    chk("R13 irq low while muted", irq, 0);
    gap(14);
    chk("R10 idle does not wake address mode", muted, 1);
    chk("R8 no idle flag while muted", idle_seen, 0);
    send(9'h041, 1'b0, 1'b0);
    chk("R10 address wakes", muted, 0);
    chk("R10 address delivered", data_rdy, 1);
    chk("R10 address word", rx_word, 9'h041);
    chk("R10 parity ok", par_err, 0);
    ack();
    gap(2);

    // R9 idle-line wake, flags held but masked while muted
    wake_on_addr = 1'b0; par_en = 1'b0; frame_long = 1'b1;
    send(9'h1C3, 1'b0, 1'b0);
    pulse_mute();
    chk("R13 irq masked by mute", irq, 0);
    chk("R8 pending rdy kept", data_rdy, 1);
    gap(2);
    send(9'h155, 1'b0, 1'b1);
    chk("R8 no overrun while muted", ovr_err, 0);
    chk("R8 no frm_err while muted", frm_err, 0);
    chk("R8 still muted", muted, 1);
    gap(14);
    chk("R9 idle wake", muted, 0);
    chk("R9 idle flag not set", idle_seen, 0);
    chk("R13 irq after wake", irq, 1);
    chk("R9 old word intact", rx_word, 9'h1C3);
    ack();

    // R12 mute request held across the waking word
    wake_on_addr = 1'b1; frame_long = 1'b0; par_en = 1'b0;
    pulse_mute();
    mute_req = 1'b1;
    send(9'h0F0, 1'b0, 1'b0);
    gap(1);
    mute_req = 1'b0;
    @(negedge clk);
    chk("R12 stays muted", muted, 1);
    chk("R12 word lost", data_rdy, 0);
    a = 9'h0E1;
    send(a, 1'b0, 1'b0);
    chk("R10 wake after lost address", muted, 0);
    chk("R10 later address word", rx_word, a);
    ack();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule